// File: doc/BRIEF.md
# Command-Register MDIO Management Master

This block runs one clause-22 management frame on an MDC/MDIO pair each time software asks for one. All control and status pass through a single 32-bit access word. Software first writes the PHY address, register address, operation code, start-of-frame code and (for a write) the data with the go bit low. It then writes the same word again with the go bit high and polls until the go bit reads back as zero. For a read, the 16 bits returned by the PHY then sit in the low half of the same word.

The serial frame is 32 preamble ones, then the start code, operation, PHY address and register address, each most significant bit first, then a two-bit turnaround and sixteen data bits. MDC is made by dividing the system clock, and it toggles only while a frame is in flight. On a read the master releases MDIO from the turnaround onward and samples the PHY's bits on each MDC rising edge.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the access word reads 0x00000000, MDC is low and the MDIO output enable is low.
- R2: A write with bit 31 low stores bits 29:0 and starts no frame. Bit 30 always reads 0. MDC stays low.
- R3: A write with bit 31 high while bit 31 reads 0 starts a frame. Bit 31 then reads 1 until the frame ends and returns to 0 by itself, with MDC low at that point.
- R4: Every frame has exactly 64 MDC rising edges. The first 32 bits are ones, followed by word bits 17:16 (start code), 19:18 (operation), 24:20 (PHY address) and 29:25 (register address), each MSB first.
- R5: When bits 19:18 are not 2'b10, the frame is a write. The master drives the turnaround as 1 then 0, then word bits 15:0 MSB first, and the output enable is high for all 64 bits.
- R6: When bits 19:18 equal 2'b10 (read), the output enable is high for the first 46 bits and low for bits 46 to 63.
- R7: On a read, MDIO is sampled at the MDC rising edge of bits 48 to 63. The first sample becomes word bit 15. At the end of the frame the 16 samples replace bits 15:0, and bits 29:16 keep their values.
- R8: Each MDC high phase lasts MDC_HALF system clocks, and each MDC period lasts 2*MDC_HALF system clocks.
- R9: MDC shows no pulse while bit 31 reads 0.
- R10: A write to the access word while bit 31 reads 1 has no effect on the frame in progress or on the word's contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the access word |
| reg_wr_data | input | 32 | Value to write to the access word |
| reg_rd_data | output | 32 | Current contents of the access word |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | High while the master drives MDIO |
| mdio_i | input | 1 | Management data seen on the pin |

## Verification
The assertions assume that mdio_i is quiet around the system-clock edge on which MDC rises. They also assume that software writes the access word only through the strobe, with no overlap between the field write and the go write. The bench PHY model changes mdio_i only on MDC falling edges, so the value is held for MDC_HALF clocks before each sample. The bench also keeps every write strobe a single clock wide, so every sampled bit and every ignored write lands inside the window the properties assume.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

    // frame geometry (clause-22): preamble + 32 header/data bits
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 32;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    // bit indices inside the frame, counted from the first preamble bit
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + 14);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_LEN + 16);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    // access word field positions (software-visible)
    localparam int GO_BIT = 31;
    localparam int RSV_BIT = 30;
    localparam logic [1:0] OP_READ = 2'b10;

    typedef struct packed {
        logic                  busy;
        logic                  mdc;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_LEN-1:0]  sh;
        logic                  rd;
        logic [15:0]           rsh;
    } seq_state_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int MDC_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(MDC_HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)                cnt_d = '0;
        else if (cnt_q == CNT_LAST) cnt_d = '0;
        else                       cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = run_i && (cnt_q == CNT_LAST);

    generate
        if (MDC_HALF > 1) begin : g_spacing
            // R8: phase edges are never on adjacent clocks when the half period exceeds one
            a_r8_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [FRAME_LEN-1:0] frame_i,
    input  logic                 is_read_i,
    input  logic                 tick_i,
    input  logic                 mdio_i,
    output logic                 run_o,
    output logic                 done_o,
    output logic [15:0]          rdata_o,
    output logic                 mdc_o,
    output logic                 mdio_o,
    output logic                 mdio_oe_o
);
    seq_state_t d, q;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (start_i) begin
                d.busy = 1'b1;
                d.mdc  = 1'b0;
                d.idx  = '0;
                d.sh   = frame_i;
                d.rd   = is_read_i;
                d.rsh  = '0;
            end
        end else if (tick_i) begin
            if (!q.mdc) begin
                // rising MDC: sample the PHY during the data field of a read
                d.mdc = 1'b1;
                if (q.rd && (q.idx >= DATA_IDX))
                    d.rsh = {q.rsh[14:0], mdio_i};
            end else begin
                // falling MDC: move to the next bit or close the frame
                d.mdc = 1'b0;
                if (q.idx == LAST_IDX) begin
                    d.busy = 1'b0;
                end else begin
                    d.idx = q.idx + IDX_W'(1);
                    d.sh  = {q.sh[FRAME_LEN-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run_o     = q.busy;
    assign done_o    = q.busy && tick_i && q.mdc && (q.idx == LAST_IDX);
    assign rdata_o   = q.rsh;
    assign mdc_o     = q.mdc;
    assign mdio_o    = q.busy ? q.sh[FRAME_LEN-1] : 1'b1;
    assign mdio_oe_o = q.busy && !(q.rd && (q.idx >= TA_IDX));

    // R8: MDC moves only on a divider tick
    a_r8_mdc_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(q.mdc));

    // R4: the preamble field always carries ones
    a_r4_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && (q.idx < IDX_W'(PRE_LEN))) |-> mdio_o);

    // R3: a new frame cannot begin while one is running
    a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !done_o) |=> q.busy);

endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
    import mdio_cmd_pkg::*;
#(
    parameter int MDC_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam logic [31:0] RSV_MASK = 32'h1 << RSV_BIT;

    logic [31:0] acc_d, acc_q;
    logic        start;
    logic        is_read;
    logic        seq_run, seq_done, tick;
    logic [15:0] rdata;
    logic [FRAME_LEN-1:0] frame;

    assign start   = reg_wr_en && !acc_q[GO_BIT] && reg_wr_data[GO_BIT];
    assign is_read = (reg_wr_data[19:18] == OP_READ);
    assign frame   = {{PRE_LEN{1'b1}}, reg_wr_data[17:16], reg_wr_data[19:18],
                      reg_wr_data[24:20], reg_wr_data[29:25], 2'b10,
                      reg_wr_data[15:0]};

    always_comb begin
        acc_d = acc_q;
        if (acc_q[GO_BIT]) begin
            if (seq_done) begin
                acc_d[GO_BIT] = 1'b0;
                if (acc_q[19:18] == OP_READ) acc_d[15:0] = rdata;
            end
        end else if (reg_wr_en) begin
            acc_d = reg_wr_data & ~RSV_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    mdio_clk_div #(.MDC_HALF(MDC_HALF)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (seq_run),
        .tick_o (tick)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .frame_i   (frame),
        .is_read_i (is_read),
        .tick_i    (tick),
        .mdio_i    (mdio_i),
        .run_o     (seq_run),
        .done_o    (seq_done),
        .rdata_o   (rdata),
        .mdc_o     (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe)
    );

    assign reg_rd_data = acc_q;

    // R9: no clock activity while the go bit is clear
    a_r9_mdc_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_q[GO_BIT] |-> !mdc);

    // R10: fields stay put under a write issued during a frame
    a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q[GO_BIT] && reg_wr_en) |=> $stable(acc_q[29:16]));

    // R3: the go bit falls with the bus parked
    a_r3_clean_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_q[GO_BIT]) |-> (!mdc && !mdio_oe));

    // R6: the pin is driven only while a frame is running
    a_r6_drive_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> acc_q[GO_BIT]);

    // R3: sequencer and access word agree on activity
    a_r3_busy_agree: assert property (@(posedge clk) disable iff (!rst_n)
        seq_run |-> acc_q[GO_BIT]);

endmodule

// File: tb/mdio_cmd_master_test.sv
`timescale 1ns/1ps
module mdio_cmd_master_test;
    localparam int HALF = 2;
    localparam real TCLK = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails = 0;

    logic [63:0] cap_d, cap_oe;
    int          ncap = 0;
    int          nrise_total = 0;
    int          width_bad = 0;
    realtime     t_rise = 0.0;
    realtime     t_prev = 0.0;
    logic [15:0] phy_data = '0;

    always #(TCLK/2.0) clk = ~clk;

    mdio_cmd_master #(.MDC_HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    // bus monitor
    always @(posedge mdc) begin
        cap_d  = {cap_d[62:0], mdio_o};
        cap_oe = {cap_oe[62:0], mdio_oe};
        if (ncap > 0 && ($realtime - t_prev) != 2.0*HALF*TCLK) width_bad++;
        t_prev = $realtime;
        t_rise = $realtime;
        ncap++;
        nrise_total++;
    end

    // PHY model: present the next bit after each falling MDC
    always @(negedge mdc) begin
        if ($realtime - t_rise != HALF*TCLK) width_bad++;
        if (ncap >= 48 && ncap < 64) mdio_i = phy_data[63-ncap];
        else if (ncap == 47)         mdio_i = 1'b0;
        else                         mdio_i = 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (reg_rd_data[31]) @(negedge clk);
    endtask

    task automatic run_frame(input logic [31:0] cmd, input logic [31:0] busy_poke);
        logic [63:0] exp_d, exp_oe, hdr_mask;
        logic        rd;
        rd = (cmd[19:18] == 2'b10);
        wr(cmd & 32'h7FFF_FFFF);
        ncap = 0;
        width_bad = 0;
        wr(cmd | 32'h8000_0000);
        check(reg_rd_data[31] == 1'b1, "R3 go bit set", {32'h0, reg_rd_data}, 64'h1);
        if (busy_poke != 32'h0) begin
            repeat (40) @(negedge clk);
            wr(busy_poke);
        end
        wait_idle();
        exp_d = {32'hFFFF_FFFF, cmd[17:16], cmd[19:18], cmd[24:20], cmd[29:25],
                 2'b10, cmd[15:0]};
        exp_oe = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        hdr_mask = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        check(ncap == 64, "R4 edge count", 64'(ncap), 64'd64);
        check(((cap_d ^ exp_d) & hdr_mask) == 64'h0,
              rd ? "R4 read header" : "R5 write frame", cap_d, exp_d);
        check(cap_oe == exp_oe, rd ? "R6 read drive window" : "R5 drive window",
              cap_oe, exp_oe);
        check(width_bad == 0, "R8 MDC timing", 64'(width_bad), 64'd0);
        check(!mdc && !mdio_oe, "R3 bus parked at end", {62'h0, mdc, mdio_oe}, 64'h0);
        if (rd)
            check(reg_rd_data == {2'b00, cmd[29:16], phy_data}, "R7 read data",
                  {32'h0, reg_rd_data}, {32'h0, 2'b00, cmd[29:16], phy_data});
        else
            check(reg_rd_data == (cmd & 32'h3FFF_FFFF),
                  busy_poke != 32'h0 ? "R10 word after busy write" : "R5 word after write",
                  {32'h0, reg_rd_data}, {32'h0, cmd & 32'h3FFF_FFFF});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(TCLK * 200000.0);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] cmd;
        int          n0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(reg_rd_data == 32'h0 && !mdc && !mdio_oe, "R1 reset state",
              {31'h0, mdc, reg_rd_data}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 store without starting, reserved bit reads zero
        n0 = nrise_total;
        wr(32'h7FFF_1234);
        check(reg_rd_data == 32'h3FFF_1234, "R2 stored fields",
              {32'h0, reg_rd_data}, 64'h3FFF_1234);
        repeat (50) @(negedge clk);
        check(nrise_total == n0, "R9 no MDC while idle", 64'(nrise_total), 64'(n0));

        // R5 write frames over every PHY address
        for (int p = 0; p < 32; p++) begin
            cmd = {2'b00, 5'((p * 7) % 32), 5'(p), 2'b01, 2'b01,
                   16'(p * 16'h0841) ^ 16'hA5C3};
            run_frame(cmd, 32'h0);
        end

        // R6 R7 read frames over every register address
        for (int r = 0; r < 32; r++) begin
            phy_data = 16'((r + 1) * 16'h1357) ^ 16'h5AA5;
            cmd = {2'b00, 5'(r), 5'(31 - r), 2'b10, 2'b01, 16'hFFFF};
            run_frame(cmd, 32'h0);
        end

        // frame with op 00 is driven as a write (R5)
        run_frame({2'b00, 5'd9, 5'd3, 2'b00, 2'b01, 16'h8001}, 32'h0);

        // R10 write during a frame is ignored
        run_frame({2'b00, 5'd17, 5'd22, 2'b01, 2'b01, 16'hC0DE}, 32'h8ABC_DEF0);
        run_frame({2'b00, 5'd4, 5'd5, 2'b01, 2'b01, 16'h0F0F}, 32'h0000_0000 | 32'h0123_4567);

        // R9 quiet again after frames
        n0 = nrise_total;
        repeat (60) @(negedge clk);
        check(nrise_total == n0 && !mdc, "R9 idle after frames",
              64'(nrise_total), 64'(n0));

        finish_run();
    end
endmodule